// File: doc/BRIEF.md
# Real-Time Clock Calendar Counter

This block keeps calendar time as a chain of packed-BCD counters: seconds, minutes, hours, day of month, month and a two-digit year. A fast enable pulse (`osc_tick`) is divided down by an internal prescaler to one event per second. On each such event the chain advances and `sec_tick_o` pulses for one clock. The hour counter runs in either 24-hour or 12-hour format. The format is picked by a bit stored inside the hour value itself, so a host can switch formats live by writing the hour field.

Host logic loads the fields through a small addressed write port. A control location holds a write-enable bit, and time fields take a write only while that bit is 1. An accepted time write freezes counting. Counting resumes when the host raises `xfer_done`, which marks the end of the write transaction. At that moment the prescaler restarts from zero, so the next second boundary falls one full prescaler period after the transaction ends.

Top module: `rtc_time_core`

## Requirements
- R1: After reset the outputs read seconds 0x00, minutes 0x00, hour 0x12 (12-hour format, AM, twelve o'clock), day 0x01, month 0x01, year 0x00, `wen_o` = 0 and `sec_tick_o` = 0.
- R2: While running, every DIV pulses of `osc_tick` produce exactly one `sec_tick_o` pulse. The new time is visible in the same cycle as that pulse.
- R3: Seconds and minutes count in BCD from 00 to 59. A ones digit of 9 carries into the tens digit, and 59 wraps to 00 with a carry into the next field.
- R4: With hour bit 6 = 1 (24-hour format), bits 5:0 hold BCD hours 00..23. Hour 23 wraps to 00 and advances the date.
- R5: With hour bit 6 = 0 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 run 12, 01 .. 11. The step 11→12 toggles bit 5. 11 PM→12 AM advances the date, and 11 AM→12 PM does not.
- R6: Months 04, 06, 09 and 11 end after day 30, and the other months except February end after day 31. The last day rolls to day 01 of the next month.
- R7: February ends after day 29 when the year value is divisible by 4, including year 00, and after day 28 otherwise.
- R8: December's last day rolls to 01/01 of the next year, and year 99 wraps to 00.
- R9: Address 6 is the control location, whose data bit 0 sets `wen_o`. Writes to addresses 0..5 (sec, min, hour, day, month, year) are ignored while `wen_o` is 0.
- R10: An accepted time write stops all ticks until `xfer_done`. After `xfer_done`, the first `sec_tick_o` comes exactly DIV `osc_tick` pulses later, whatever partial count the prescaler held before.
- R11: `xfer_done` with no accepted time write since the last release leaves the prescaler phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Prescaler enable pulse |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address (0 sec .. 5 year, 6 control) |
| wr_data | input | 8 | Write data |
| xfer_done | input | 1 | End-of-write-transaction strobe |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Hour with format (bit 6) and PM (bit 5) |
| day_o | output | 8 | BCD day of month |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| wen_o | output | 1 | Write-enable control bit |
| sec_tick_o | output | 1 | One-cycle pulse per second |

## Verification
Time is preloaded just ahead of each boundary, and every expected second is compared with the design's output. The boundaries are a ones-digit carry inside a minute, 24-hour midnight into a new year, the noon and midnight steps of 12-hour mode, and the 12→1 step. February ends are tried in a year divisible by 4, in a year that is not, and in year 00, and 30-day and 31-day month ends are tried as well. Together these separate carry chains that stop too early or too late and month-length tables that are wrong. Separately, the distance from `xfer_done` to the first tick is measured after a write made with a partially filled prescaler and after a release with no write. This shows whether the phase is really reset, and only when a write was made. A write while the enable bit is clear, and ticking while a write is pending, are both checked to have no visible effect.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned ADDR_W  = 3;
    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_DAY  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd4;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd6;

    localparam int unsigned HR_FMT24 = 6;
    localparam int unsigned HR_PM    = 5;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] day;
        logic [7:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        rtc_time_t t;
        logic      wen;
        logic      halt;
        logic      tick;
    } core_st_t;

    // Next value of a two-digit packed BCD number (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return v + 8'd1;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic hold,
    output logic wrap
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = osc_tick && !hold && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (hold) begin
            cnt_d = '0;
        end else if (osc_tick) begin
            cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [7:0] mon_i,
    input  logic       year_tens_odd_i,
    input  logic [1:0] year_ones_lo_i,
    output logic [7:0] last_day_o
);
    logic [1:0] mod4;
    logic       leap;

    always_comb begin
        // tens*10 mod 4 equals 2 when tens is odd; ones mod 4 is its low bits
        mod4 = (year_tens_odd_i ? 2'd2 : 2'd0) + year_ones_lo_i;
        leap = (mod4 == 2'd0);
        unique case (mon_i)
            8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
            default:                    last_day_o = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_hour_next.sv
module rtc_hour_next
    import rtc_pkg::*;
(
    input  logic [7:0] hour_i,
    output logic [7:0] next_o,
    output logic       day_carry_o
);
    logic       pm;
    logic [3:0] ones;
    logic [1:0] tens24;
    logic       tens12;

    always_comb begin
        pm          = hour_i[HR_PM];
        ones        = hour_i[3:0];
        tens24      = hour_i[5:4];
        tens12      = hour_i[4];
        day_carry_o = 1'b0;
        next_o      = hour_i;
        if (hour_i[HR_FMT24]) begin
            if (hour_i[5:0] == 6'h23) begin
                next_o      = {hour_i[7], 1'b1, 6'h00};
                day_carry_o = 1'b1;
            end else if (ones >= 4'd9) begin
                next_o = {hour_i[7], 1'b1, tens24 + 2'd1, 4'd0};
            end else begin
                next_o = {hour_i[7], 1'b1, tens24, ones + 4'd1};
            end
        end else begin
            if (hour_i[4:0] == 5'h11) begin
                next_o      = {hour_i[7], 1'b0, ~pm, 5'h12};
                day_carry_o = pm;
            end else if (hour_i[4:0] == 5'h12) begin
                next_o = {hour_i[7], 1'b0, pm, 5'h01};
            end else if (ones >= 4'd9) begin
                next_o = {hour_i[7], 1'b0, pm, 1'b1, 4'd0};
            end else begin
                next_o = {hour_i[7], 1'b0, pm, tens12, ones + 4'd1};
            end
        end
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int unsigned DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       wr_valid,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       xfer_done,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] day_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       wen_o,
    output logic       sec_tick_o
);
    localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h12,
                                       day: 8'h01, mon: 8'h01, year: 8'h00};

    core_st_t   st_d, st_q;
    logic       time_wr;
    logic       hold;
    logic       wrap;
    logic [7:0] hour_nx;
    logic       day_carry;
    logic [7:0] last_day;

    rtc_prescaler #(.DIV(DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_tick(osc_tick),
        .hold    (hold),
        .wrap    (wrap)
    );

    rtc_hour_next u_hour (
        .hour_i     (st_q.t.hour),
        .next_o     (hour_nx),
        .day_carry_o(day_carry)
    );

    rtc_month_len u_mlen (
        .mon_i          (st_q.t.mon),
        .year_tens_odd_i(st_q.t.year[4]),
        .year_ones_lo_i (st_q.t.year[1:0]),
        .last_day_o     (last_day)
    );

    always_comb begin
        time_wr = wr_valid && st_q.wen && (wr_addr <= A_YEAR);
        hold    = st_q.halt || time_wr;
        st_d      = st_q;
        st_d.tick = wrap;

        if (wrap) begin
            if (st_q.t.sec == 8'h59) begin
                st_d.t.sec = 8'h00;
                if (st_q.t.min == 8'h59) begin
                    st_d.t.min  = 8'h00;
                    st_d.t.hour = hour_nx;
                    if (day_carry) begin
                        if (st_q.t.day == last_day) begin
                            st_d.t.day = 8'h01;
                            if (st_q.t.mon == 8'h12) begin
                                st_d.t.mon  = 8'h01;
                                st_d.t.year = (st_q.t.year == 8'h99) ? 8'h00
                                                                     : bcd_inc(st_q.t.year);
                            end else begin
                                st_d.t.mon = bcd_inc(st_q.t.mon);
                            end
                        end else begin
                            st_d.t.day = bcd_inc(st_q.t.day);
                        end
                    end
                end else begin
                    st_d.t.min = bcd_inc(st_q.t.min);
                end
            end else begin
                st_d.t.sec = bcd_inc(st_q.t.sec);
            end
        end

        if (wr_valid && (wr_addr == A_CTRL)) begin
            st_d.wen = wr_data[0];
        end

        if (time_wr) begin
            unique case (wr_addr)
                A_SEC:   st_d.t.sec  = wr_data;
                A_MIN:   st_d.t.min  = wr_data;
                A_HOUR:  st_d.t.hour = wr_data;
                A_DAY:   st_d.t.day  = wr_data;
                A_MON:   st_d.t.mon  = wr_data;
                default: st_d.t.year = wr_data;
            endcase
        end

        st_d.halt = (st_q.halt && !xfer_done) || time_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{t: TIME_RST, wen: 1'b0, halt: 1'b0, tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o      = st_q.t.sec;
    assign min_o      = st_q.t.min;
    assign hour_o     = st_q.t.hour;
    assign day_o      = st_q.t.day;
    assign mon_o      = st_q.t.mon;
    assign year_o     = st_q.t.year;
    assign wen_o      = st_q.wen;
    assign sec_tick_o = st_q.tick;

endmodule

// File: rtl/rtc_time_core_chk.sv
module rtc_time_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic [2:0] wr_addr,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] day_o,
    input logic [7:0] mon_o,
    input logic [7:0] year_o,
    input logic       wen_o,
    input logic       sec_tick_o
);

    // R2: every second event changes the seconds field
    a_r2_tick_moves_sec: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_o |-> (sec_o != $past(sec_o)));

    // R4: 23:59:59 in 24-hour format steps to 00 and a new day
    a_r4_midnight_24h: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick_o && $past(hour_o) == 8'h63 && $past(min_o) == 8'h59 && $past(sec_o) == 8'h59)
        |-> (hour_o == 8'h40 && day_o != $past(day_o)));

    // R5: 11 AM -> 12 PM keeps the date
    a_r5_noon: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick_o && $past(hour_o) == 8'h11 && $past(min_o) == 8'h59 && $past(sec_o) == 8'h59)
        |-> (hour_o == 8'h32 && $stable(day_o)));

    // R5: 11 PM -> 12 AM advances the date
    a_r5_midnight_12h: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick_o && $past(hour_o) == 8'h31 && $past(min_o) == 8'h59 && $past(sec_o) == 8'h59)
        |-> (hour_o == 8'h12 && day_o != $past(day_o)));

    // R9: without the enable bit, fields move only on a second event
    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wen_o) && !sec_tick_o)
        |-> $stable({sec_o, min_o, hour_o, day_o, mon_o, year_o}));

    // R10: an accepted time write suppresses the next tick
    a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr <= 3'd5 && wen_o) |=> !sec_tick_o);

endmodule

bind rtc_time_core rtc_time_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour_o),
    .day_o     (day_o),
    .mon_o     (mon_o),
    .year_o    (year_o),
    .wen_o     (wen_o),
    .sec_tick_o(sec_tick_o)
);

// File: tb/rtc_time_core_tb_top.sv
module rtc_time_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       xfer_done = 1'b0;
    logic [7:0] sec_o, min_o, hour_o, day_o, mon_o, year_o;
    logic       wen_o, sec_tick_o;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit done_rep = 1'b0;
    logic [47:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_time_core #(.DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .xfer_done(xfer_done),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
        .mon_o(mon_o), .year_o(year_o), .wen_o(wen_o), .sec_tick_o(sec_tick_o)
    );

    task automatic check(input bit ok, input string req, input logic [47:0] act,
                         input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done_rep) begin
            done_rep = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    endtask

    // Scoreboard monitor: each second event pops one expected time
    always @(negedge clk) begin
        if (rst_n && mon_on && sec_tick_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected tick", {sec_o, min_o, hour_o, day_o, mon_o, year_o}, '0);
            end else begin
                automatic logic [47:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check({sec_o, min_o, hour_o, day_o, mon_o, year_o} == e, t,
                      {sec_o, min_o, hour_o, day_o, mon_o, year_o}, e);
            end
        end
    end

    task automatic push(input logic [7:0] s, m, h, d, mo, y, input string t);
        exp_q.push_back({s, m, h, d, mo, y});
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, m, h, d, mo, y);
        wr(3'd6, 8'h01);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h);
        wr(3'd3, d); wr(3'd4, mo); wr(3'd5, y);
        done_pulse();
    endtask

    task automatic run_secs(input int n);
        @(negedge clk);
        osc_tick = 1'b1;
        repeat (n * DIV) @(negedge clk);
        osc_tick = 1'b0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected ticks seen", 48'(exp_q.size()), 48'd0);
        exp_q.delete(); tag_q.delete();
    endtask

    // Enable osc_tick and count cycles to the first second event
    task automatic cycles_to_tick(output int n);
        n = 0;
        osc_tick = 1'b1;
        while (n < 100) begin
            @(negedge clk);
            n++;
            if (sec_tick_o) break;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        report();
    end

    initial begin
        int n;
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check(sec_o == 8'h00, "R1 sec", 48'(sec_o), 48'h00);
        check(min_o == 8'h00, "R1 min", 48'(min_o), 48'h00);
        check(hour_o == 8'h12, "R1 hour", 48'(hour_o), 48'h12);
        check(day_o == 8'h01, "R1 day", 48'(day_o), 48'h01);
        check(mon_o == 8'h01, "R1 mon", 48'(mon_o), 48'h01);
        check(year_o == 8'h00, "R1 year", 48'(year_o), 48'h00);
        check(wen_o == 1'b0, "R1 wen", 48'(wen_o), 48'h0);
        check(sec_tick_o == 1'b0, "R1 tick", 48'(sec_tick_o), 48'h0);

        // R9: write ignored while enable is clear
        wr(3'd0, 8'h30);
        wr(3'd5, 8'h77);
        done_pulse();
        check(sec_o == 8'h00, "R9 gated sec", 48'(sec_o), 48'h00);
        check(year_o == 8'h00, "R9 gated year", 48'(year_o), 48'h00);
        wr(3'd6, 8'h01);
        check(wen_o == 1'b1, "R9 enable set", 48'(wen_o), 48'h1);

        mon_on = 1'b1;
        // R3 ones-digit carry in seconds
        set_time(8'h09, 8'h12, 8'h05, 8'h10, 8'h03, 8'h21);
        push(8'h10, 8'h12, 8'h05, 8'h10, 8'h03, 8'h21, "R3 sec carry");
        run_secs(1);
        // R4 R8 24-hour midnight into new year, year 99 -> 00
        set_time(8'h58, 8'h59, 8'h63, 8'h31, 8'h12, 8'h99);
        push(8'h59, 8'h59, 8'h63, 8'h31, 8'h12, 8'h99, "R3 sec step");
        push(8'h00, 8'h00, 8'h40, 8'h01, 8'h01, 8'h00, "R4 R8 year end");
        run_secs(2);
        // R5 11 AM -> 12 PM, same day
        set_time(8'h59, 8'h59, 8'h11, 8'h15, 8'h06, 8'h24);
        push(8'h00, 8'h00, 8'h32, 8'h15, 8'h06, 8'h24, "R5 noon");
        run_secs(1);
        // R5 R7 11 PM Feb 28 non-leap -> 12 AM Mar 1
        set_time(8'h59, 8'h59, 8'h31, 8'h28, 8'h02, 8'h23);
        push(8'h00, 8'h00, 8'h12, 8'h01, 8'h03, 8'h23, "R5 R7 midnight non-leap");
        run_secs(1);
        // R5 12 PM -> 1 PM
        set_time(8'h59, 8'h59, 8'h32, 8'h10, 8'h07, 8'h24);
        push(8'h00, 8'h00, 8'h21, 8'h10, 8'h07, 8'h24, "R5 twelve to one");
        run_secs(1);
        // R7 leap year Feb 28 -> 29
        set_time(8'h59, 8'h59, 8'h63, 8'h28, 8'h02, 8'h24);
        push(8'h00, 8'h00, 8'h40, 8'h29, 8'h02, 8'h24, "R7 leap feb 29");
        run_secs(1);
        // R7 Feb 29 -> Mar 1
        set_time(8'h59, 8'h59, 8'h63, 8'h29, 8'h02, 8'h24);
        push(8'h00, 8'h00, 8'h40, 8'h01, 8'h03, 8'h24, "R7 leap end");
        run_secs(1);
        // R7 year 00 treated as leap
        set_time(8'h59, 8'h59, 8'h63, 8'h28, 8'h02, 8'h00);
        push(8'h00, 8'h00, 8'h40, 8'h29, 8'h02, 8'h00, "R7 year 00 leap");
        run_secs(1);
        // R6 30-day month end
        set_time(8'h59, 8'h59, 8'h63, 8'h30, 8'h04, 8'h25);
        push(8'h00, 8'h00, 8'h40, 8'h01, 8'h05, 8'h25, "R6 april end");
        run_secs(1);
        // R6 31-day month does not end at 30
        set_time(8'h59, 8'h59, 8'h63, 8'h30, 8'h01, 8'h25);
        push(8'h00, 8'h00, 8'h40, 8'h31, 8'h01, 8'h25, "R6 january 31");
        run_secs(1);
        mon_on = 1'b0;

        // R10: pending write blocks ticks
        wr(3'd1, 8'h20);
        keep = sec_o;
        n = 0;
        osc_tick = 1'b1;
        repeat (3 * DIV) begin
            @(negedge clk);
            if (sec_tick_o) n++;
        end
        osc_tick = 1'b0;
        check(n == 0 && sec_o == keep, "R10 halted no tick", 48'(n), 48'd0);
        done_pulse();
        cycles_to_tick(n);
        check(n == DIV, "R10 first tick after release", 48'(n), 48'(DIV));
        // R10: partial phase discarded by write + release
        repeat (2) @(negedge clk);
        osc_tick = 1'b0;
        wr(3'd0, 8'h05);
        done_pulse();
        cycles_to_tick(n);
        check(n == DIV, "R10 phase realigned", 48'(n), 48'(DIV));
        // R11: release without write keeps the phase
        repeat (2) @(negedge clk);
        osc_tick = 1'b0;
        done_pulse();
        cycles_to_tick(n);
        check(n == DIV - 2, "R11 phase kept", 48'(n), 48'(DIV - 2));
        osc_tick = 1'b0;

        repeat (3) @(negedge clk);
        report();
    end

endmodule